// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the multiply-accumulate stage of a 16-bit fixed-point signal processing datapath. Each clock it takes two 16-bit operands and an operation code. It then does one of four things to a 40-bit accumulator: loads it with the product, adds the product to it, subtracts the product from it, or clears it. Every operation finishes in one cycle. The updated accumulator appears on the output ports right after the clock edge, so the next cycle can use it.

Each operand has its own flag that selects a signed or an unsigned reading. Mixed-sign products are therefore possible, which multiprecision routines need for their partial products. Above the 32-bit product the accumulator carries 8 guard bits. An overflow flag reports when the value no longer fits in 32 signed bits. A saturate operation clamps an overflowed value to the largest 32-bit magnitude of the matching sign. A rounding request adds half of the low word before the high word is taken. The accumulator is presented as three separately readable fields: guard byte, high word and low word.

Top module: `mac_unit`

## Requirements
- R1: After reset the accumulator is zero in all three fields and the overflow flag is low.
- R2: Operation code 1 loads the accumulator with the product a*b. The product is sign-extended to 40 bits. Each operand is read as two's complement when its signed flag is 1 and as unsigned when its flag is 0.
- R3: Operation code 2 replaces the accumulator with the accumulator plus the product.
- R4: Operation code 3 replaces the accumulator with the accumulator minus the product.
- R5: Operation code 4 clears the accumulator to zero. Operands and rounding have no effect on it.
- R6: Operation code 0 and the unused codes 6 and 7 leave the accumulator unchanged.
- R7: The overflow flag is high exactly when accumulator bits 39 down to 31 are not all equal.
- R8: Operation code 5 with the overflow flag high loads 0x007FFFFFFF when bit 39 is 0, or 0xFF80000000 when bit 39 is 1. With the flag low it leaves the accumulator unchanged.
- R9: When the rounding input is high during codes 1, 2 or 3, the value 0x8000 is also added to the result.
- R10: Accumulation wraps modulo 2^40 and is not clamped automatically.
- R11: The result of an operation is visible on acc_ext (bits 39:32), acc_hi (bits 31:16) and acc_lo (bits 15:0) after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| a_signed | input | 1 | First operand read as two's complement |
| b_signed | input | 1 | Second operand read as two's complement |
| round_en | input | 1 | Add 0x8000 to the result of codes 1 to 3 |
| acc_ext | output | 8 | Accumulator guard bits 39:32 |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| ovf | output | 1 | Accumulator exceeds the 32-bit signed range |

## Verification
The accumulator is the only state, and all 40 of its bits reach the ports. A wrong product, a lost carry into the guard byte, or a wrong sign extension therefore shows on the output fields one cycle after the operation that caused it. A running accumulation keeps that error in every later sample, so the bench compares all fields after every operation and catches it at once. A flag or saturation fault shows at the ports in the same cycle that the accumulator crosses the 32-bit range.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic          round_en,
  output logic [GW-1:0] acc_ext,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          ovf
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;
  localparam int XW = AW - PW - 2;

  localparam logic [2:0] OP_MUL = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_SUB = 3'd3;
  localparam logic [2:0] OP_CLR = 3'd4;
  localparam logic [2:0] OP_SAT = 3'd5;

  localparam logic [AW-1:0] POS_MAX = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MAX = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};
  localparam logic [AW-1:0] HALF    = AW'(1) << (DW - 1);

  logic [AW-1:0]         acc;
  logic signed [DW:0]    ax, bx;
  logic signed [PW+1:0]  prod_s;
  logic [AW-1:0]         prod, rnd, nxt;
  logic                  wide;

  assign ax     = {a_signed & a[DW-1], a};
  assign bx     = {b_signed & b[DW-1], b};
  assign prod_s = ax * bx;
  assign prod   = {{XW{prod_s[PW+1]}}, prod_s};
  assign rnd    = round_en ? HALF : '0;
  assign wide   = (|acc[AW-1:PW-1]) & ~(&acc[AW-1:PW-1]);

  always_comb begin
    case (op)
      OP_MUL:  nxt = prod + rnd;
      OP_ADD:  nxt = acc + prod + rnd;
      OP_SUB:  nxt = acc - prod + rnd;
      OP_CLR:  nxt = '0;
      OP_SAT:  nxt = wide ? (acc[AW-1] ? NEG_MAX : POS_MAX) : acc;
      default: nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= nxt;
  end

  assign acc_ext = acc[AW-1:PW];
  assign acc_hi  = acc[PW-1:DW];
  assign acc_lo  = acc[DW-1:0];
  assign ovf     = wide;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic          round_en,
  input logic [GW-1:0] acc_ext,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo,
  input logic          ovf
);
  logic [2*DW+GW-1:0] v;
  assign v = {acc_ext, acc_hi, acc_lo};

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd4 |=> (v == '0 && !ovf));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op == 3'd6 || op == 3'd7) |=> $stable(v));

  assert_sat_clears_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5 && ovf) |=> !ovf);

  assert_sat_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5 && !ovf) |=> $stable(v));

  assert_zero_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && !round_en && (a == '0 || b == '0)) |=> v == '0);

  assert_add_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd2 || op == 3'd3) && !round_en && a == '0) |=> $stable(v));
endmodule

bind mac_unit mac_unit_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .round_en(round_en),
  .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf(ovf)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] a = '0, b = '0;
  logic        a_signed = 1'b0, b_signed = 1'b0, round_en = 1'b0;
  logic [7:0]  acc_ext;
  logic [15:0] acc_hi, acc_lo;
  logic        ovf;

  int unsigned n_chk = 0, n_bad = 0;
  logic [39:0] model = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
    .a_signed(a_signed), .b_signed(b_signed), .round_en(round_en),
    .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf(ovf)
  );

  function automatic bit exp_ovf(input logic [39:0] m);
    return !(m[39:31] == 9'h000 || m[39:31] == 9'h1FF);
  endfunction

  task automatic check(input string tag);
    logic [39:0] got;
    got = {acc_ext, acc_hi, acc_lo};
    n_chk++;
    if (got !== model) begin
      n_bad++;
      $display("FAIL %s acc actual=%010h expected=%010h", tag, got, model);
    end
    n_chk++;
    if (ovf !== exp_ovf(model)) begin
      n_bad++;
      $display("FAIL %s ovf actual=%0b expected=%0b", tag, ovf, exp_ovf(model));
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                      input bit xs, input bit ys, input bit r, input string tag);
    longint av, bv, p, rv;
    op = o; a = x; b = y; a_signed = xs; b_signed = ys; round_en = r;
    av = xs ? longint'($signed(x)) : longint'(x);
    bv = ys ? longint'($signed(y)) : longint'(y);
    p  = av * bv;
    rv = r ? 64'h8000 : 64'h0;
    case (o)
      3'd1: model = 40'(p + rv);
      3'd2: model = model + 40'(p) + 40'(rv);
      3'd3: model = model - 40'(p) + 40'(rv);
      3'd4: model = '0;
      3'd5: if (exp_ovf(model)) model = model[39] ? 40'hFF80000000 : 40'h007FFFFFFF;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFFFE, 16'h0002};
    repeat (3) @(posedge clk);
    @(negedge clk);
    model = '0;
    check("R1 reset");
    rst_n = 1'b1;

    // R2 R3 R4 R9 R11: sweep of corner operands, sign modes, ops, rounding
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 4; s++) begin
          step(3'd1, vals[i], vals[j], s[0], s[1], (i + j) % 2 == 1, "R2 multiply");
          step(3'd2, vals[j], vals[i], s[1], s[0], s == 2, "R3 multiply-add");
          step(3'd3, vals[i], vals[i], s[0], s[0], j == 3, "R4 multiply-subtract");
          step(3'd2, vals[i], vals[j], s[0], s[1], 1'b1, "R9 round");
        end

    // R5 clear with junk inputs
    step(3'd4, 16'hFFFF, 16'h8000, 1'b1, 1'b0, 1'b1, "R5 clear");
    // R6 hold codes
    step(3'd1, 16'h1234, 16'h5678, 1'b1, 1'b1, 1'b0, "R2 load");
    step(3'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R6 nop");
    step(3'd6, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R6 code6");
    step(3'd7, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, "R6 code7");
    // R8 saturate without overflow holds
    step(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R8 sat no ovf");

    // R7 R8 positive overflow then saturate
    step(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R5 clear");
    for (int k = 0; k < 5; k++)
      step(3'd2, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0, "R7 positive growth");
    step(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R8 sat positive");
    // R7 R8 negative overflow then saturate
    for (int k = 0; k < 8; k++)
      step(3'd3, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0, "R7 negative growth");
    step(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R8 sat negative");

    // R10 wrap around 2^40 with unsigned products
    step(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R5 clear");
    for (int k = 0; k < 300; k++)
      step(3'd2, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R10 wrap");
    for (int k = 0; k < 300; k++)
      step(3'd3, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, k[0], "R10 unwrap");

    // R1 reset in the middle of a run
    rst_n = 1'b0;
    op = 3'd2;
    @(posedge clk);
    @(negedge clk);
    model = '0;
    check("R1 mid reset");
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule